// File: doc/BRIEF.md
# Five-Bit Teleprinter Case Tracker

This block keeps track of the letters/figures case of a five-bit teleprinter code in both directions of a terminal link. Keyboard and printer share one case register. On the keyboard side, each service step takes a key code that has already been translated. The code carries five data bits, a figures flag and an either-case flag. If the key needs the other case, the block first hands the CPU the case-change code. It then holds the character back and delivers it on the following step.

On the printer side, the block takes five-bit codes from the CPU. A case-change code only moves the shared case register. Every other code comes out as a six-bit print index: the current case bit placed above the five data bits, ready to address a glyph table. Each side has a sticky done flag that its own clear strobe resets.

Top module: `baudot_case_unit`

## Requirements
- R1: After reset the case is letters (`case_figs` = 0), nothing is pending, both done flags are 0, `kbd_code` is 0 and `prn_print` is 0.
- R2: A keyboard step with a key whose bit 6 (either-case) is 1, or whose bit 5 (figures) equals `case_figs`, delivers `key_code[4:0]` on `kbd_code` one cycle later and leaves the case unchanged.
- R3: A keyboard step with a key whose bits 6..5 are 0,1 under letters, or 0,0 under figures, delivers the case-change code for the case the key needs: figures 5'o33, letters 5'o37. In the same cycle the case takes the value of bit 5 and `kbd_pending` rises.
- R4: The next keyboard step after R3 delivers the held five-bit character and clears `kbd_pending`. Any key offered on that step is ignored and cannot change the case.
- R5: A keyboard step with `key_code` = 0 and nothing pending delivers nothing: `kbd_code`, `kbd_done` and `case_figs` are unchanged.
- R6: Printer code 5'o33 sets the case to figures and 5'o37 sets it to letters. Neither raises `prn_print`.
- R7: Any other printer code raises `prn_print` for one cycle with `prn_index` = {case before the code, code}, and leaves the case unchanged.
- R8: Every keyboard delivery sets `kbd_done` and every accepted printer code sets `prn_done`. `kbd_clr` and `prn_clr` clear their flags, and a set in the same cycle wins over a clear.
- R9: If the keyboard side and a printer case-change code both write the case in the same cycle, the printer value is kept. The keyboard output and its held character are not affected.
- R10: With `kbd_step` low, `key_code` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kbd_step | input | 1 | Keyboard service step strobe |
| key_code | input | 7 | Translated key: [4:0] code, [5] figures, [6] either-case; 0 = untranslatable |
| kbd_clr | input | 1 | Clears the keyboard done flag |
| kbd_code | output | 5 | Last code delivered to the CPU |
| kbd_done | output | 1 | Keyboard done flag |
| kbd_pending | output | 1 | A held character awaits the next step |
| prn_valid | input | 1 | Printer code strobe |
| prn_code | input | 5 | Code from the CPU for printing |
| prn_clr | input | 1 | Clears the printer done flag |
| prn_print | output | 1 | One-cycle pulse: `prn_index` is a new printable index |
| prn_index | output | 6 | {case, code} glyph index |
| prn_done | output | 1 | Printer done flag |
| case_figs | output | 1 | Shared case: 1 = figures, 0 = letters |

## Verification
The hardest state to reach from the ports is a same-cycle collision on the shared case register. It only happens when a keyboard key forces a case change in the very cycle a printer case-change code arrives. The bench drives both strobes on one edge, in both directions. It then checks that the printer value survives and that the held character still drains on the next step. A second awkward state is a step that lands while a character is held. The bench offers a key of the opposite case on that step and shows that both the case and the delivered code ignore it. Around these targeted cases, every key code is swept from both starting cases and every printer code from both cases.

// File: rtl/baudot_case_pkg.sv
package baudot_case_pkg;

  typedef enum logic {
    CASE_LTRS = 1'b0,
    CASE_FIGS = 1'b1
  } case_e;

endpackage

// File: rtl/case_state_reg.sv
module case_state_reg
  import baudot_case_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  kbd_wr,
  input  case_e kbd_val,
  input  logic  prn_wr,
  input  case_e prn_val,
  output case_e state
);

  case_e state_d;
  case_e state_q;

  // Printer writes outrank keyboard writes.
  always_comb begin
    state_d = state_q;
    if (prn_wr)      state_d = prn_val;
    else if (kbd_wr) state_d = kbd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CASE_LTRS;
    else        state_q <= state_d;
  end

  assign state = state_q;

  assert_printer_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prn_wr |=> state_q == $past(prn_val));

  assert_kbd_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_wr && !prn_wr) |=> state_q == $past(kbd_val));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_wr && !prn_wr) |=> $stable(state_q));

endmodule

// File: rtl/kbd_case_seq.sv
module kbd_case_seq
  import baudot_case_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] LTRS_CODE = 5'o37,
  parameter logic [CODE_W-1:0] FIGS_CODE = 5'o33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [CODE_W+1:0] key,
  input  logic              clr,
  input  case_e             case_now,
  output logic [CODE_W-1:0] code,
  output logic              done,
  output logic              pending,
  output logic              case_wr,
  output case_e             case_val
);

  localparam int FIG_BIT = CODE_W;
  localparam int ANY_BIT = CODE_W + 1;

  logic [CODE_W-1:0] code_d, code_q;
  logic [CODE_W-1:0] held_d, held_q;
  logic              held_v_d, held_v_q;
  logic              done_d, done_q;
  logic              fire;
  logic              key_fits;
  case_e             key_case;

  assign key_case = case_e'(key[FIG_BIT]);
  assign key_fits = key[ANY_BIT] || (key_case == case_now);

  always_comb begin
    code_d   = code_q;
    held_d   = held_q;
    held_v_d = held_v_q;
    fire     = 1'b0;
    case_wr  = 1'b0;
    case_val = case_now;
    if (step) begin
      if (held_v_q) begin
        code_d   = held_q;
        held_v_d = 1'b0;
        fire     = 1'b1;
      end else if (key != '0) begin
        fire = 1'b1;
        if (key_fits) begin
          code_d = key[CODE_W-1:0];
        end else begin
          code_d   = (key_case == CASE_FIGS) ? FIGS_CODE : LTRS_CODE;
          case_wr  = 1'b1;
          case_val = key_case;
          held_d   = key[CODE_W-1:0];
          held_v_d = 1'b1;
        end
      end
    end
    if (fire)     done_d = 1'b1;
    else if (clr) done_d = 1'b0;
    else          done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      held_q   <= '0;
      held_v_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      code_q   <= code_d;
      held_q   <= held_d;
      held_v_q <= held_v_d;
      done_q   <= done_d;
    end
  end

  assign code    = code_q;
  assign done    = done_q;
  assign pending = held_v_q;

  assert_held_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && held_v_q) |=> (!held_v_q && code_q == $past(held_q)));

  assert_shift_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_v_q) |-> (code_q == LTRS_CODE || code_q == FIGS_CODE));

  assert_delivery_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> done_q);

  assert_null_key_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !held_v_q && key == '0) |=> $stable(code_q));

  assert_no_step_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(code_q) && $stable(held_v_q)));

endmodule

// File: rtl/prn_case_decode.sv
module prn_case_decode
  import baudot_case_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] LTRS_CODE = 5'o37,
  parameter logic [CODE_W-1:0] FIGS_CODE = 5'o33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  logic              clr,
  input  case_e             case_now,
  output logic [CODE_W:0]   index,
  output logic              print,
  output logic              done,
  output logic              case_wr,
  output case_e             case_val
);

  logic [CODE_W:0] index_d, index_q;
  logic            print_d, print_q;
  logic            done_d, done_q;
  logic            is_figs, is_ltrs;

  assign is_figs = (code == FIGS_CODE);
  assign is_ltrs = (code == LTRS_CODE);

  always_comb begin
    case_wr  = valid && (is_figs || is_ltrs);
    case_val = is_figs ? CASE_FIGS : CASE_LTRS;
    print_d  = valid && !is_figs && !is_ltrs;
    index_d  = print_d ? {case_now, code} : index_q;
    if (valid)    done_d = 1'b1;
    else if (clr) done_d = 1'b0;
    else          done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      print_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      index_q <= index_d;
      print_q <= print_d;
      done_q  <= done_d;
    end
  end

  assign index = index_q;
  assign print = print_q;
  assign done  = done_q;

  assert_shift_not_printed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    print_q |-> (index_q[CODE_W-1:0] != FIGS_CODE && index_q[CODE_W-1:0] != LTRS_CODE));

  assert_print_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !case_wr) |=> (print_q && index_q == {$past(case_now), $past(code)}));

  assert_printer_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> done_q);

endmodule

// File: rtl/baudot_case_unit.sv
module baudot_case_unit
  import baudot_case_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] LTRS_CODE = 5'o37,
  parameter logic [CODE_W-1:0] FIGS_CODE = 5'o33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_step,
  input  logic [CODE_W+1:0] key_code,
  input  logic              kbd_clr,
  output logic [CODE_W-1:0] kbd_code,
  output logic              kbd_done,
  output logic              kbd_pending,
  input  logic              prn_valid,
  input  logic [CODE_W-1:0] prn_code,
  input  logic              prn_clr,
  output logic              prn_print,
  output logic [CODE_W:0]   prn_index,
  output logic              prn_done,
  output logic              case_figs
);

  localparam int SYNC_DEPTH = 2;

  logic [SYNC_DEPTH-1:0] rst_pipe;
  logic                  rst_int_n;
  case_e                 case_now;
  logic                  kbd_wr, prn_wr;
  case_e                 kbd_val, prn_val;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_DEPTH-1];

  case_state_reg u_case (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .kbd_wr  (kbd_wr),
    .kbd_val (kbd_val),
    .prn_wr  (prn_wr),
    .prn_val (prn_val),
    .state   (case_now)
  );

  kbd_case_seq #(
    .CODE_W    (CODE_W),
    .LTRS_CODE (LTRS_CODE),
    .FIGS_CODE (FIGS_CODE)
  ) u_kbd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (kbd_step),
    .key      (key_code),
    .clr      (kbd_clr),
    .case_now (case_now),
    .code     (kbd_code),
    .done     (kbd_done),
    .pending  (kbd_pending),
    .case_wr  (kbd_wr),
    .case_val (kbd_val)
  );

  prn_case_decode #(
    .CODE_W    (CODE_W),
    .LTRS_CODE (LTRS_CODE),
    .FIGS_CODE (FIGS_CODE)
  ) u_prn (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .valid    (prn_valid),
    .code     (prn_code),
    .clr      (prn_clr),
    .case_now (case_now),
    .index    (prn_index),
    .print    (prn_print),
    .done     (prn_done),
    .case_wr  (prn_wr),
    .case_val (prn_val)
  );

  assign case_figs = (case_now == CASE_FIGS);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!kbd_pending && !kbd_done && !prn_done && !prn_print && !case_figs));

endmodule

// File: tb/baudot_case_unit_test.sv
module baudot_case_unit_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       kbd_step, kbd_clr, prn_valid, prn_clr;
  logic [6:0] key_code;
  logic [4:0] prn_code;
  logic [4:0] kbd_code;
  logic       kbd_done, kbd_pending, prn_print, prn_done, case_figs;
  logic [5:0] prn_index;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  localparam logic [4:0] LT = 5'o37;
  localparam logic [4:0] FG = 5'o33;

  always #5 clk = ~clk;

  baudot_case_unit uut (
    .clk(clk), .rst_n(rst_n), .kbd_step(kbd_step), .key_code(key_code),
    .kbd_clr(kbd_clr), .kbd_code(kbd_code), .kbd_done(kbd_done),
    .kbd_pending(kbd_pending), .prn_valid(prn_valid), .prn_code(prn_code),
    .prn_clr(prn_clr), .prn_print(prn_print), .prn_index(prn_index),
    .prn_done(prn_done), .case_figs(case_figs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    kbd_step = 0; kbd_clr = 0; prn_valid = 0; prn_clr = 0;
    key_code = '0; prn_code = '0;
  endtask

  // Printer code for one cycle; outputs sampled at the next falling edge.
  task automatic prn(input logic [4:0] c);
    @(negedge clk); idle(); prn_valid = 1; prn_code = c;
    @(negedge clk); idle();
  endtask

  task automatic set_case(input bit f);
    prn(f ? FG : LT);
    chk(case_figs == f, "R6", case_figs, f);
    chk(prn_print == 0, "R6", prn_print, 0);
  endtask

  task automatic kstep(input logic [6:0] k);
    @(negedge clk); idle(); kbd_clr = 1;
    @(negedge clk); idle(); kbd_step = 1; key_code = k;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(case_figs == 0, "R1", case_figs, 0);
    chk(kbd_pending == 0, "R1", kbd_pending, 0);
    chk(kbd_done == 0, "R1", kbd_done, 0);
    chk(prn_done == 0, "R1", prn_done, 0);
    chk(kbd_code == 0, "R1", kbd_code, 0);
    chk(prn_print == 0, "R1", prn_print, 0);

    // R10: key without step does nothing
    @(negedge clk); idle(); key_code = 7'h21;
    repeat (2) @(negedge clk);
    chk(kbd_code == 0 && kbd_done == 0 && case_figs == 0, "R10", kbd_code, 0);
    idle();

    // Keyboard sweep: every key from both cases
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 128; k++) begin
        logic [6:0] kk;
        logic [6:0] other;
        logic [4:0] prev;
        bit kf, fits;
        kk = 7'(k);
        set_case(s[0]);
        prev = kbd_code;
        kf = kk[5];
        fits = kk[6] || (kf == s[0]);
        kstep(kk);
        if (kk == 0) begin
          chk(kbd_done == 0, "R5", kbd_done, 0);
          chk(kbd_code == prev, "R5", kbd_code, prev);
          chk(case_figs == s[0], "R5", case_figs, s);
        end else if (fits) begin
          chk(kbd_code == kk[4:0], "R2", kbd_code, kk[4:0]);
          chk(kbd_done == 1 && kbd_pending == 0, "R2", kbd_done, 1);
          chk(case_figs == s[0], "R2", case_figs, s);
        end else begin
          chk(kbd_code == (kf ? FG : LT), "R3", kbd_code, kf ? FG : LT);
          chk(kbd_pending == 1 && kbd_done == 1, "R3", kbd_pending, 1);
          chk(case_figs == kf, "R3", case_figs, kf);
          // Offer an opposite-case key; it must be ignored (R4)
          other = {1'b0, ~kf, 5'h01};
          kstep(other);
          chk(kbd_code == kk[4:0], "R4", kbd_code, kk[4:0]);
          chk(kbd_pending == 0 && kbd_done == 1, "R4", kbd_pending, 0);
          chk(case_figs == kf, "R4", case_figs, kf);
        end
      end
    end

    // Printer sweep: every code from both cases
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 32; c++) begin
        logic [4:0] cc;
        cc = 5'(c);
        set_case(s[0]);
        @(negedge clk); idle(); prn_clr = 1;
        @(negedge clk); idle();
        chk(prn_done == 0, "R8", prn_done, 0);
        prn(cc);
        chk(prn_done == 1, "R8", prn_done, 1);
        if (cc == FG) begin
          chk(prn_print == 0 && case_figs == 1, "R6", case_figs, 1);
        end else if (cc == LT) begin
          chk(prn_print == 0 && case_figs == 0, "R6", case_figs, 0);
        end else begin
          chk(prn_print == 1, "R7", prn_print, 1);
          chk(prn_index == {s[0], cc}, "R7", prn_index, {s[0], cc});
          chk(case_figs == s[0], "R7", case_figs, s);
          @(negedge clk);
          chk(prn_print == 0, "R7", prn_print, 0);
        end
      end
    end

    // R8: set wins over clear on the same cycle
    @(negedge clk); idle(); kbd_step = 1; kbd_clr = 1; key_code = 7'h41;
    @(negedge clk); idle();
    chk(kbd_done == 1, "R8", kbd_done, 1);
    @(negedge clk); idle(); kbd_clr = 1;
    @(negedge clk); idle();
    chk(kbd_done == 0, "R8", kbd_done, 0);

    // R9: collision, keyboard wants figures, printer says letters
    set_case(1'b0);
    @(negedge clk); idle(); kbd_step = 1; key_code = 7'h23; prn_valid = 1; prn_code = LT;
    @(negedge clk); idle();
    chk(kbd_code == FG && kbd_pending == 1, "R9", kbd_code, FG);
    chk(case_figs == 0, "R9", case_figs, 0);
    kstep(7'h00);
    chk(kbd_code == 5'h03 && kbd_pending == 0, "R9", kbd_code, 3);

    // R9: collision, keyboard wants letters, printer says figures
    set_case(1'b1);
    @(negedge clk); idle(); kbd_step = 1; key_code = 7'h05; prn_valid = 1; prn_code = FG;
    @(negedge clk); idle();
    chk(kbd_code == LT && case_figs == 1, "R9", case_figs, 1);
    kstep(7'h00);
    chk(kbd_code == 5'h05, "R9", kbd_code, 5);

    // R9: printer non-shift code does not block a keyboard case write
    set_case(1'b0);
    @(negedge clk); idle(); kbd_step = 1; key_code = 7'h22; prn_valid = 1; prn_code = 5'h04;
    @(negedge clk); idle();
    chk(case_figs == 1, "R9", case_figs, 1);
    chk(prn_index == 6'h04 && prn_print == 1, "R7", prn_index, 4);
    kstep(7'h00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule